// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of one Serial Wire Debug transfer. A user pulses a start strobe together with a command. The command holds a port select (debug port or access port), a direction, a two-bit register address and a 32-bit write word. The engine then builds its own serial clock from the system clock through a programmable divider. It shifts out the packet header and releases the data line for the turnaround cycles. It captures the three-bit target response and then either sends the word with its parity or receives one. Trailing idle clocks close the transfer.

The data line is handled as three separate signals: an input from the pad, an output value and an output enable that is low whenever the target owns the line. On completion the engine pulses `done` and presents the response code. For reads it also presents the received word and a flag that is raised when the received parity disagrees with the word. Retrying after a busy or error response is left to the user.

Top module: `swd_host_engine`

## Requirements
- R1: The 8-bit header is driven in line order: 1, port select (1 = access port), direction (1 = read), address bit 0, address bit 1, a parity bit, 0, 1. The parity bit is the XOR of the four command bits.
- R2: On a write with an OK response, the 32 data bits are driven least significant bit first on line bits 13 to 44. Line bit 45 carries a parity bit that is 1 when the word holds an odd number of ones.
- R3: The output enable is low on line bit 8 in every transfer. On an OK write it is also low for bits 9 to 12 and high for 13 to 53. On an OK read it stays low from bit 8 through bit 45.
- R4: The three response bits are sampled on line bits 9, 10 and 11, with the first one received going into `ack[0]`. OK is the value 3'b001.
- R5: On an OK read, line bits 12 to 43 are returned as `rdata`, least significant bit first. `parity_err` is 1 exactly when line bit 44 differs from the word's odd-ones parity.
- R6: A response other than OK ends the transfer after one turnaround (line bit 12), 13 clocks in all. No data phase follows, and `rdata` reads 0.
- R7: After an OK data phase the host drives the line low for 8 further clocks (bits 46 to 53), giving 54 clocks per OK transfer.
- R8: The serial clock period is 2*(clk_div+1) system clocks. The host changes its output value and enable only while the serial clock is low, and it samples the line on the rising edge.
- R9: Out of reset and while idle, the serial clock is low and the host drives the line low with the enable high. `busy` and `done` are 0.
- R10: `busy` is high from the cycle after an accepted start until the transfer ends. `done` is a one-cycle pulse at that end, and a start strobe raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half period of the serial clock minus one, in system clocks |
| cmd_start | input | 1 | Start strobe, accepted while idle |
| cmd_ap | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_rnw | input | 1 | 1 for a read, 0 for a write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack | output | 3 | Captured response code |
| rdata | output | 32 | Received word |
| parity_err | output | 1 | Received parity mismatch |
| swclk | output | 1 | Generated serial clock |
| swdio_in | input | 1 | Data line level from the pad |
| swdio_out | output | 1 | Value driven onto the data line |
| swdio_oe | output | 1 | Drive enable for the data line |

## Verification
A bench model of the target answers on the data line, and the bench records the enable and value of every host-driven bit, so the whole line is compared against expected values. Writes are tried with both port selects, with words of odd and even parity and with an all-ones word, which separates the parity rules from data ordering. Reads are tried with asymmetric words such as one with only its end bits set, which exposes a reversed bit order, and one read receives a wrong parity bit to trip the error flag. Busy and error responses show that the data phase is skipped. Divider settings of 0 and 3 check the clock period, and a second start strobe during a transfer must leave it untouched.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_REQ, PH_TRN_A, PH_ACK, PH_TRN_W,
    PH_WDATA, PH_RDATA, PH_TRN_R, PH_TAIL, PH_TRN_F
  } phase_e;

  localparam int          WORD_BITS = 32;
  localparam int          CNT_W     = 6;
  localparam logic [2:0]  ACK_OK    = 3'b001;

  // Header in line order, bit 0 first on the wire.
  function automatic logic [7:0] build_request(input logic ap, input logic rnw,
                                               input logic [1:0] addr);
    logic par;
    par = ap ^ rnw ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

  function automatic logic word_parity(input logic [WORD_BITS-1:0] w);
    return ^w;
  endfunction

  function automatic logic [CNT_W-1:0] phase_len(input phase_e p);
    case (p)
      PH_REQ:            return CNT_W'(8);
      PH_ACK:            return CNT_W'(3);
      PH_WDATA, PH_RDATA: return CNT_W'(WORD_BITS + 1);
      PH_TAIL:           return CNT_W'(8);
      default:           return CNT_W'(1);
    endcase
  endfunction

  function automatic phase_e phase_after(input phase_e p, input logic rnw,
                                         input logic ack_ok);
    case (p)
      PH_REQ:   return PH_TRN_A;
      PH_TRN_A: return PH_ACK;
      PH_ACK:   return !ack_ok ? PH_TRN_F : (rnw ? PH_RDATA : PH_TRN_W);
      PH_TRN_W: return PH_WDATA;
      PH_WDATA: return PH_TAIL;
      PH_RDATA: return PH_TRN_R;
      PH_TRN_R: return PH_TAIL;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             swclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == div);
  assign rise_tick = wrap && !swclk;
  assign fall_tick = wrap && swclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      swclk <= ~swclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_phase_seq.sv
module swd_phase_seq
  import swd_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rnw,
  input  logic             ack_ok,
  input  logic             fall_tick,
  output phase_e           phase,
  output logic [CNT_W-1:0] bitcnt,
  output logic             done
);
  phase_e nxt;
  logic   last_bit;

  assign last_bit = (bitcnt == phase_len(phase) - CNT_W'(1));
  assign nxt      = phase_after(phase, rnw, ack_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase  <= PH_REQ;
          bitcnt <= '0;
        end
      end else if (fall_tick) begin
        if (last_bit) begin
          bitcnt <= '0;
          phase  <= nxt;
          done   <= (nxt == PH_IDLE);
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture
  import swd_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sample,
  input  phase_e               phase,
  input  logic [CNT_W-1:0]     bitcnt,
  input  logic                 din,
  output logic [2:0]           ack,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 par_err
);
  logic [WORD_BITS:0] rsh;

  assign rdata = rsh[WORD_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= '0;
      rsh     <= '0;
      par_err <= 1'b0;
    end else if (clear) begin
      ack     <= '0;
      rsh     <= '0;
      par_err <= 1'b0;
    end else if (sample) begin
      if (phase == PH_ACK)
        ack <= {din, ack[2:1]};
      if (phase == PH_RDATA) begin
        rsh <= {din, rsh[WORD_BITS:1]};
        if (bitcnt == CNT_W'(WORD_BITS))
          par_err <= word_parity(rsh[WORD_BITS:1]) ^ din;
      end
    end
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_start,
  input  logic             cmd_ap,
  input  logic             cmd_rnw,
  input  logic [1:0]       cmd_addr,
  input  logic [31:0]      cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic [2:0]       ack,
  output logic [31:0]      rdata,
  output logic             parity_err,
  output logic             swclk,
  input  logic             swdio_in,
  output logic             swdio_out,
  output logic             swdio_oe
);
  phase_e           phase;
  logic [CNT_W-1:0] bitcnt;
  logic             accept;
  logic             rise_tick;
  logic             fall_tick;
  logic             ack_ok;
  logic             l_ap, l_rnw;
  logic [1:0]       l_addr;
  logic [31:0]      l_wdata;
  logic [7:0]       req_vec;
  logic [32:0]      wr_vec;

  assign busy    = (phase != PH_IDLE);
  assign accept  = cmd_start && !busy;
  assign ack_ok  = (ack == ACK_OK);
  assign req_vec = build_request(l_ap, l_rnw, l_addr);
  assign wr_vec  = {word_parity(l_wdata), l_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ap    <= 1'b0;
      l_rnw   <= 1'b0;
      l_addr  <= '0;
      l_wdata <= '0;
    end else if (accept) begin
      l_ap    <= cmd_ap;
      l_rnw   <= cmd_rnw;
      l_addr  <= cmd_addr;
      l_wdata <= cmd_wdata;
    end
  end

  swd_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div),
    .swclk(swclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  swd_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .rnw(l_rnw), .ack_ok(ack_ok),
    .fall_tick(fall_tick), .phase(phase), .bitcnt(bitcnt), .done(done)
  );

  swd_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(rise_tick),
    .phase(phase), .bitcnt(bitcnt), .din(swdio_in),
    .ack(ack), .rdata(rdata), .par_err(parity_err)
  );

  // Line ownership and value per phase.
  always_comb begin
    swdio_oe  = 1'b0;
    swdio_out = 1'b0;
    case (phase)
      PH_IDLE, PH_TAIL: swdio_oe = 1'b1;
      PH_REQ: begin
        swdio_oe  = 1'b1;
        swdio_out = req_vec[bitcnt[2:0]];
      end
      PH_WDATA: begin
        swdio_oe  = 1'b1;
        swdio_out = wr_vec[bitcnt];
      end
      default: begin
        swdio_oe  = 1'b0;
        swdio_out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic swclk,
  input logic swdio_out,
  input logic swdio_oe,
  input logic rise_tick,
  input logic fall_tick
);
  a_r8_out_changes_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swdio_out) |-> !swclk);

  a_r8_oe_changes_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swdio_oe) |-> !swclk);

  a_r8_rise_sets_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> swclk);

  a_r8_fall_clears_clock: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !swclk);

  a_r9_idle_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swdio_oe && !swdio_out && !swclk));

  a_r1_first_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (swdio_oe && swdio_out));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind swd_host_engine swd_host_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .swclk(swclk),
  .swdio_out(swdio_out), .swdio_oe(swdio_oe),
  .rise_tick(rise_tick), .fall_tick(fall_tick)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int NVEC       = 7;
  // {ap, rnw, addr[1:0], word[31:0], target ack[2:0], corrupt parity}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd1, 32'h1234_5678, 3'b001, 1'b0},
    {1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, 3'b001, 1'b0},
    {1'b0, 1'b1, 2'd0, 32'h0BB1_1477, 3'b001, 1'b0},
    {1'b1, 1'b1, 2'd2, 32'h8000_0001, 3'b001, 1'b0},
    {1'b1, 1'b1, 2'd1, 32'hA5A5_0F0F, 3'b001, 1'b1},
    {1'b0, 1'b0, 2'd2, 32'hDEAD_BEEF, 3'b010, 1'b0},
    {1'b1, 1'b1, 2'd3, 32'h0000_0000, 3'b100, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div = 8'd1;
  logic             cmd_start = 1'b0, cmd_ap = 1'b0, cmd_rnw = 1'b0;
  logic [1:0]       cmd_addr = 2'd0;
  logic [31:0]      cmd_wdata = 32'd0;
  logic             busy, done, parity_err, swclk, swdio_out, swdio_oe;
  logic [2:0]       ack;
  logic [31:0]      rdata;
  logic             swdio_in;

  int checks = 0, fails = 0;
  int cyc = 0, last_rise = 0, period = 0;
  int fall_cnt = 0, base = 0, cur;
  logic [63:0] tvec = '0, hoev = '0, houtv = '0;

  swd_host_engine #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_start(cmd_start),
    .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .ack(ack), .rdata(rdata), .parity_err(parity_err),
    .swclk(swclk), .swdio_in(swdio_in), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  assign cur      = fall_cnt - base;
  assign swdio_in = tvec[cur[5:0]];

  // Target side: next bit presented after each falling edge.
  always @(negedge swclk) fall_cnt = fall_cnt + 1;
  always @(posedge swclk) begin
    hoev[cur[5:0]]  = swdio_oe;
    houtv[cur[5:0]] = swdio_out;
    period    = cyc - last_rise;
    last_rise = cyc;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic odd_ones(input logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) if (w[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic run_txn(input logic ap, input logic rnw, input logic [1:0] addr,
                         input logic [31:0] word, input logic [2:0] tack,
                         input logic badpar, input logic disturb);
    logic [7:0]  ereq;
    logic [63:0] eoe, mask;
    logic        okk;
    int          n, nbits, exp_bits;
    okk  = (tack == 3'b001);
    ereq = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    tvec = '0;
    tvec[9] = tack[0]; tvec[10] = tack[1]; tvec[11] = tack[2];
    if (rnw && okk) begin
      for (int i = 0; i < 32; i++) tvec[12+i] = word[i];
      tvec[44] = odd_ones(word) ^ badpar;
    end
    @(negedge clk);
    base = fall_cnt;
    cmd_ap = ap; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = word; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (disturb && n == 40) begin
        cmd_start = 1'b1; cmd_ap = ~ap; cmd_rnw = ~rnw; cmd_addr = ~addr;
      end else cmd_start = 1'b0;
    end
    cmd_start = 1'b0;
    check(n < 20000, "R10 watchdog: done seen", 64'(n), 64'd0);
    nbits    = fall_cnt - base;
    exp_bits = okk ? 54 : 13;
    check(nbits == exp_bits, okk ? "R7 clocks per OK transfer" : "R6 clocks on non-OK",
          64'(nbits), 64'(exp_bits));
    check(houtv[7:0] == ereq && hoev[7:0] == 8'hFF, "R1 header bits",
          {hoev[7:0], houtv[7:0]}, {8'hFF, ereq});
    eoe = '0; mask = '0;
    for (int i = 0; i < exp_bits; i++) begin
      mask[i] = 1'b1;
      if (i < 8) eoe[i] = 1'b1;
      else if (okk && !rnw && i >= 13) eoe[i] = 1'b1;
      else if (okk && rnw && i >= 46) eoe[i] = 1'b1;
    end
    check((hoev & mask) == eoe, "R3 turnaround and drive enable", hoev & mask, eoe);
    check(ack == tack, "R4 captured ack", 64'(ack), 64'(tack));
    if (okk && !rnw) begin
      logic [32:0] got;
      for (int i = 0; i < 33; i++) got[i] = houtv[13+i];
      check(got == {odd_ones(word), word}, "R2 write data and parity",
            64'(got), 64'({odd_ones(word), word}));
    end
    if (okk && rnw) begin
      check(rdata == word, "R5 read data", 64'(rdata), 64'(word));
      check(parity_err == badpar, "R5 parity error flag", 64'(parity_err), 64'(badpar));
    end
    if (okk) begin
      logic [7:0] to, tv;
      for (int i = 0; i < 8; i++) begin to[i] = hoev[46+i]; tv[i] = houtv[46+i]; end
      check(to == 8'hFF && tv == 8'h00, "R7 idle tail driven low",
            {to, tv}, 16'hFF00);
    end else begin
      check(rdata == 32'd0, "R6 no data phase after non-OK", 64'(rdata), 64'd0);
    end
    check(!busy, "R10 busy low after done", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!swclk && swdio_oe && !swdio_out && !busy && !done, "R9 reset state",
          {swclk, swdio_oe, swdio_out, busy, done}, 5'b01000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!swclk && swdio_oe && !swdio_out && !busy, "R9 idle after reset",
          {swclk, swdio_oe, swdio_out, busy}, 4'b0100);

    for (int v = 0; v < NVEC; v++)
      run_txn(VEC[v][39], VEC[v][38], VEC[v][37:36], VEC[v][35:4], VEC[v][3:1],
              VEC[v][0], 1'b0);

    // R8 divider settings
    clk_div = 8'd3;
    run_txn(1'b1, 1'b0, 2'd0, 32'h0000_0003, 3'b001, 1'b0, 1'b0);
    check(period == 8, "R8 period with div 3", 64'(period), 64'd8);
    clk_div = 8'd0;
    run_txn(1'b0, 1'b1, 2'd3, 32'h7FFF_FFFE, 3'b001, 1'b0, 1'b0);
    check(period == 2, "R8 period with div 0", 64'(period), 64'd2);

    // R10 start while busy is ignored (header and data come from the first command)
    clk_div = 8'd1;
    run_txn(1'b0, 1'b0, 2'd2, 32'h0F0F_00FF, 3'b001, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL R10 global watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule